// File: doc/BRIEF.md
# Table-Driven Power Sequence Engine

This block walks a table of packed sequence entries and carries out each one on a byte-wide register bus. A start pulse makes it fetch entries one at a time from a synchronous table port, beginning at entry 0. Each entry is filtered against the current chip revision and host interface. An entry that applies performs one of five operations: a masked read, a masked read-modify-write, a bounded masked poll, a delay counted in microsecond or millisecond units, or an end marker.

The engine reports busy while it runs and done when it stops. It has two sticky error flags: one for a poll that ran out of attempts and one for an unknown operation code. The register bus uses a request/acknowledge handshake. A free-running microsecond tick input paces the delays.

Top module: `pwrseq_engine`

## Requirements
- R1: An entry is 52 bits wide. The fields, from the top bit down, are: op [51:48], base [47:44], offset [43:28], revision mask [27:20], interface mask [19:16], bit mask [15:8] and value [7:0]. The entry at `tbl_addr` appears on `tbl_data` in the cycle after `tbl_rd`. An entry is skipped, with no bus request, when revision mask bit `cfg_rev` is 0 or interface mask bit `cfg_intf` is 0. A skipped entry is not decoded further, so even an unknown op in it has no effect.
- R2: Bus transfers use the address {base, offset} (20 bits). `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay steady until a cycle with `bus_ack` high. `bus_rdata` is taken in that cycle.
- R3: Op 0 (read) issues one bus read. It then pulses `rd_valid` for one cycle with `rd_data` = read data AND bit mask.
- R4: Op 1 (write) reads the register first. It then writes (old AND NOT mask) OR (value AND mask) to the same address.
- R5: Op 2 (poll) rereads the register until (data AND mask) equals (value AND mask), and then moves on to the next entry.
- R6: A poll that gets POLL_LIMIT (default 20000) mismatching reads sets the sticky `err_timeout`, asserts `done` and stops. A match on the last allowed read counts as success.
- R7: Op 3 (delay) with value bit 0 = 0 waits for `offset` pulses of `us_tick` that arrive after the entry is decoded.
- R8: A delay with value bit 0 = 1 waits for offset × MS_TICKS (default 1000) tick pulses. A delay with offset 0 completes at once, with no ticks needed.
- R9: Op 4 (end) stops the sequence: `busy` falls, `done` rises, and later entries are neither fetched nor executed.
- R10: An applicable entry with op above 4 sets the sticky `err_cmd`, asserts `done` and stops with no bus access.
- R11: After reset, `busy`, `done`, `err_timeout`, `err_cmd`, `bus_req` and `tbl_rd` are all 0. A `start` while idle clears `done` and both error flags and runs from entry 0. `busy` is high from the cycle after `start` until the sequence stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken while idle |
| cfg_rev | input | 3 | Current revision index (0 = test chip … 7) |
| cfg_intf | input | 2 | Current host interface index (0 SDIO, 1 USB, 2 PCI, 3 spare) |
| tbl_rd | output | 1 | Table read strobe |
| tbl_addr | output | TBL_AW | Table entry index |
| tbl_data | input | 52 | Entry returned one cycle after the strobe |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write transfer |
| bus_addr | output | 20 | {base, offset} |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Transfer completes in this cycle |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| us_tick | input | 1 | One-cycle microsecond pulse |
| rd_valid | output | 1 | Masked read result valid |
| rd_data | output | 8 | Masked read result |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence stopped, held until next start |
| err_timeout | output | 1 | Sticky poll timeout |
| err_cmd | output | 1 | Sticky unknown operation |

## Verification
The two functions that can meet in one cycle are the poll data match and the exhaustion of the attempt budget. On the final allowed read, the compare says "matched" in the same cycle in which the attempt counter says "last". The bench provokes this with a register that returns a mismatching value for exactly POLL_LIMIT−1 reads and the target value on the next read. It judges the outcome by the exact count of poll reads, a clear `err_timeout`, and the following read entry actually appearing on the bus. A second run shifts the match one read later, and the same judgement must then show exactly POLL_LIMIT reads, the flag set, and no further transfer.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int OP_W       = 4;
  localparam int BASE_W     = 4;
  localparam int OFF_W      = 16;
  localparam int REV_N      = 8;
  localparam int INTF_N     = 4;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = BASE_W + OFF_W;
  localparam int ENTRY_W    = OP_W + BASE_W + OFF_W + REV_N + INTF_N + 2 * BYTE_W;
  localparam int REV_SEL_W  = $clog2(REV_N);
  localparam int INTF_SEL_W = $clog2(INTF_N);

  typedef enum logic [OP_W-1:0] {
    OP_READ  = 4'd0,
    OP_WRITE = 4'd1,
    OP_POLL  = 4'd2,
    OP_DELAY = 4'd3,
    OP_END   = 4'd4
  } op_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [BASE_W-1:0] base;
    logic [OFF_W-1:0]  offset;
    logic [REV_N-1:0]  rev_mask;
    logic [INTF_N-1:0] intf_mask;
    logic [BYTE_W-1:0] bmask;
    logic [BYTE_W-1:0] value;
  } entry_t;

  // Keep old bits outside the mask, take new bits inside it.
  function automatic logic [BYTE_W-1:0] merge_bits(input logic [BYTE_W-1:0] old_v,
                                                   input logic [BYTE_W-1:0] msk,
                                                   input logic [BYTE_W-1:0] new_v);
    return (old_v & ~msk) | (new_v & msk);
  endfunction

  // True when every masked bit of data agrees with the target.
  function automatic logic masked_equal(input logic [BYTE_W-1:0] data,
                                        input logic [BYTE_W-1:0] msk,
                                        input logic [BYTE_W-1:0] target);
    return ((data ^ target) & msk) == '0;
  endfunction

endpackage

// File: rtl/pwrseq_gate.sv
module pwrseq_gate
  import pwrseq_pkg::*;
(
  input  logic [REV_N-1:0]      rev_mask,
  input  logic [INTF_N-1:0]     intf_mask,
  input  logic [REV_SEL_W-1:0]  rev_sel,
  input  logic [INTF_SEL_W-1:0] intf_sel,
  output logic                  hit
);

  logic [REV_N-1:0]  rev_oh;
  logic [INTF_N-1:0] intf_oh;

  for (genvar i = 0; i < REV_N; i++) begin : g_rev
    assign rev_oh[i] = (rev_sel == REV_SEL_W'(i));
  end

  for (genvar j = 0; j < INTF_N; j++) begin : g_intf
    assign intf_oh[j] = (intf_sel == INTF_SEL_W'(j));
  end

  assign hit = (|(rev_mask & rev_oh)) && (|(intf_mask & intf_oh));

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CNT_W    = 16,
  parameter int MS_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  input  logic             unit_ms,
  input  logic             tick,
  output logic             running,
  output logic             expire
);

  localparam int SUB_W = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(MS_TICKS - 1);

  logic [CNT_W-1:0] remain;
  logic [SUB_W-1:0] sub;
  logic             ms_q;
  logic             unit_step;

  // One whole unit has elapsed on this tick.
  assign unit_step = running && tick && (!ms_q || sub == SUB_LAST);
  assign expire    = unit_step && (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      remain  <= '0;
      sub     <= '0;
      ms_q    <= 1'b0;
    end else if (load) begin
      running <= (count != '0);
      remain  <= count;
      sub     <= '0;
      ms_q    <= unit_ms;
    end else if (running && tick) begin
      if (ms_q) sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
      if (unit_step) begin
        remain <= remain - 1'b1;
        if (remain == CNT_W'(1)) running <= 1'b0;
      end
    end
  end

  p_run_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (remain != '0));

  p_expire_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !running);

endmodule

// File: rtl/pwrseq_tries.sv
module pwrseq_tries #(
  parameter int LIMIT = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  // Number of mismatches seen so far equals LIMIT-1: the next miss is final.
  assign last = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clear)             cnt <= '0;
    else if (step && !last)     cnt <= cnt + 1'b1;
  end

  p_tries_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));

endmodule

// File: rtl/pwrseq_engine.sv
module pwrseq_engine
  import pwrseq_pkg::*;
#(
  parameter int TBL_AW     = 6,
  parameter int POLL_LIMIT = 20000,
  parameter int MS_TICKS   = 1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [REV_SEL_W-1:0]  cfg_rev,
  input  logic [INTF_SEL_W-1:0] cfg_intf,
  output logic                  tbl_rd,
  output logic [TBL_AW-1:0]     tbl_addr,
  input  logic [ENTRY_W-1:0]    tbl_data,
  output logic                  bus_req,
  output logic                  bus_we,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [BYTE_W-1:0]     bus_wdata,
  input  logic                  bus_ack,
  input  logic [BYTE_W-1:0]     bus_rdata,
  input  logic                  us_tick,
  output logic                  rd_valid,
  output logic [BYTE_W-1:0]     rd_data,
  output logic                  busy,
  output logic                  done,
  output logic                  err_timeout,
  output logic                  err_cmd
);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_RD, S_WR, S_WAIT
  } state_e;

  state_e            state;
  logic [TBL_AW-1:0] ptr;
  entry_t            ent;
  entry_t            dec;

  // Named internal events
  logic hit, ev_skip, ev_end, ev_badop, rd_ack, wr_ack;
  logic poll_ok, poll_miss, tries_last, ev_timeout;
  logic dly_load, dly_running, dly_expire;

  assign dec = tbl_data;

  pwrseq_gate u_gate (
    .rev_mask  (dec.rev_mask),
    .intf_mask (dec.intf_mask),
    .rev_sel   (cfg_rev),
    .intf_sel  (cfg_intf),
    .hit       (hit)
  );

  assign ev_skip  = (state == S_DECODE) && !hit;
  assign ev_end   = (state == S_DECODE) && hit && (dec.op == OP_END);
  assign ev_badop = (state == S_DECODE) && hit && (dec.op > OP_END);
  assign rd_ack   = (state == S_RD) && bus_ack;
  assign wr_ack   = (state == S_WR) && bus_ack;
  assign poll_ok  = rd_ack && (ent.op == OP_POLL) &&  masked_equal(bus_rdata, ent.bmask, ent.value);
  assign poll_miss= rd_ack && (ent.op == OP_POLL) && !masked_equal(bus_rdata, ent.bmask, ent.value);
  assign ev_timeout = poll_miss && tries_last;
  assign dly_load = (state == S_DECODE) && hit && (dec.op == OP_DELAY) && (dec.offset != '0);

  pwrseq_tries #(.LIMIT(POLL_LIMIT)) u_tries (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state == S_DECODE),
    .step  (poll_miss),
    .last  (tries_last)
  );

  pwrseq_timer #(.CNT_W(OFF_W), .MS_TICKS(MS_TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (dly_load),
    .count   (dec.offset),
    .unit_ms (dec.value[0]),
    .tick    (us_tick),
    .running (dly_running),
    .expire  (dly_expire)
  );

  assign tbl_rd   = (state == S_FETCH);
  assign tbl_addr = ptr;
  assign bus_req  = (state == S_RD) || (state == S_WR);
  assign bus_we   = (state == S_WR);
  assign bus_addr = {ent.base, ent.offset};
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      ptr         <= '0;
      ent         <= '0;
      bus_wdata   <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      done        <= 1'b0;
      err_timeout <= 1'b0;
      err_cmd     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            ptr         <= '0;
            done        <= 1'b0;
            err_timeout <= 1'b0;
            err_cmd     <= 1'b0;
            state       <= S_FETCH;
          end
        end
        S_FETCH: state <= S_DECODE;
        S_DECODE: begin
          ent <= dec;
          if (!hit) begin
            ptr   <= ptr + 1'b1;
            state <= S_FETCH;
          end else begin
            case (dec.op)
              OP_READ, OP_WRITE, OP_POLL: state <= S_RD;
              OP_DELAY: begin
                if (dec.offset == '0) begin
                  ptr   <= ptr + 1'b1;
                  state <= S_FETCH;
                end else begin
                  state <= S_WAIT;
                end
              end
              OP_END: begin
                done  <= 1'b1;
                state <= S_IDLE;
              end
              default: begin
                err_cmd <= 1'b1;
                done    <= 1'b1;
                state   <= S_IDLE;
              end
            endcase
          end
        end
        S_RD: begin
          if (bus_ack) begin
            case (ent.op)
              OP_READ: begin
                rd_data  <= bus_rdata & ent.bmask;
                rd_valid <= 1'b1;
                ptr      <= ptr + 1'b1;
                state    <= S_FETCH;
              end
              OP_WRITE: begin
                bus_wdata <= merge_bits(bus_rdata, ent.bmask, ent.value);
                state     <= S_WR;
              end
              default: begin
                if (poll_ok) begin
                  ptr   <= ptr + 1'b1;
                  state <= S_FETCH;
                end else if (ev_timeout) begin
                  err_timeout <= 1'b1;
                  done        <= 1'b1;
                  state       <= S_IDLE;
                end
              end
            endcase
          end
        end
        S_WR: begin
          if (wr_ack) begin
            ptr   <= ptr + 1'b1;
            state <= S_FETCH;
          end
        end
        S_WAIT: begin
          if (dly_expire) begin
            ptr   <= ptr + 1'b1;
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_skip_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> (!bus_req && tbl_rd));

  p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  p_rdv_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_req && bus_ack && !bus_we));

  p_wr_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (((bus_wdata ^ ent.value) & ent.bmask) == '0));

  p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we) |-> $past(bus_req && bus_ack && !bus_we));

  p_wait_timer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> dly_running);

  p_timeout_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> (done && !busy));

  p_end_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> (done && !busy && !tbl_rd));

  p_badop_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_cmd) |-> (done && !busy));

  p_busy_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

endmodule

// File: tb/pwrseq_engine_tb_top.sv
module pwrseq_engine_tb_top;
  import pwrseq_pkg::*;

  localparam int AW       = 6;
  localparam int LIMIT    = 20000;
  localparam int MS_UNITS = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                  start = 1'b0;
  logic [REV_SEL_W-1:0]  cfg_rev = 3'd3;
  logic [INTF_SEL_W-1:0] cfg_intf = 2'd1;
  logic                  tbl_rd;
  logic [AW-1:0]         tbl_addr;
  logic [ENTRY_W-1:0]    tbl_data = '0;
  logic                  bus_req, bus_we;
  logic [ADDR_W-1:0]     bus_addr;
  logic [7:0]            bus_wdata;
  logic                  bus_ack = 1'b0;
  logic [7:0]            bus_rdata = '0;
  logic                  us_tick = 1'b0;
  logic                  rd_valid;
  logic [7:0]            rd_data;
  logic                  busy, done, err_timeout, err_cmd;

  pwrseq_engine #(.TBL_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_rev(cfg_rev), .cfg_intf(cfg_intf),
    .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .us_tick(us_tick),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
    .err_timeout(err_timeout), .err_cmd(err_cmd)
  );

  // ---------------- models ----------------
  logic [ENTRY_W-1:0] tbl  [0:63];
  logic [7:0]         regs [0:255];
  int poll_total = 0;
  int poll_base  = 0;
  int poll_miss_n = 0;
  localparam logic [7:0] POLL_MISS = 8'h00;
  localparam logic [7:0] POLL_HIT  = 8'h81;

  always @(posedge clk) if (tbl_rd) tbl_data <= tbl[tbl_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) regs[bus_addr[7:0]] <= bus_wdata;
      else if (bus_addr[7:0] == 8'h40) begin
        bus_rdata  <= ((poll_total - poll_base) < poll_miss_n) ? POLL_MISS : POLL_HIT;
        poll_total <= poll_total + 1;
      end else bus_rdata <= regs[bus_addr[7:0]];
    end else begin
      bus_ack <= 1'b0;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct packed { logic we; logic [ADDR_W-1:0] addr; logic [7:0] data; } xfer_t;
  xfer_t      exp_q[$];
  logic [7:0] rd_q[$];
  bit         count_mode = 1'b0;
  int         poll_seen  = 0;
  int         n_tests = 0;
  int         n_fail  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ENTRY_W-1:0] mk(input logic [3:0] op, input logic [3:0] base,
      input logic [15:0] off, input logic [7:0] rev, input logic [3:0] intf,
      input logic [7:0] m, input logic [7:0] v);
    return {op, base, off, rev, intf, m, v};
  endfunction

  task automatic push_x(input logic we, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    exp_q.push_back({we, a, d});
  endtask

  // monitor: compares each completed transfer and each read result
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req && bus_ack) begin
        if (count_mode && !bus_we && bus_addr == 20'h00040) begin
          poll_seen++;
        end else if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected transfer addr", 32'(bus_addr), 32'hFFFFFFFF);
        end else begin
          xfer_t e;
          e = exp_q.pop_front();
          chk(bus_we == e.we && bus_addr == e.addr &&
              (bus_we ? bus_wdata : bus_rdata) == e.data, "R2/R4 transfer",
              "we,addr,data", {3'd0, bus_we, bus_addr, (bus_we ? bus_wdata : bus_rdata)},
              {3'd0, e.we, e.addr, e.data});
        end
      end
      if (rd_valid) begin
        if (rd_q.size() == 0) chk(1'b0, "R3", "unexpected rd_valid", 32'(rd_data), 32'hFFFFFFFF);
        else begin
          logic [7:0] r;
          r = rd_q.pop_front();
          chk(rd_data == r, "R3", "rd_data", 32'(rd_data), 32'(r));
        end
      end
    end
  end

  // ---------------- driver helpers ----------------
  task automatic clear_tbl();
    for (int i = 0; i < 64; i++) tbl[i] = mk(4'd4, 4'd0, 16'd0, 8'hFF, 4'hF, 8'h00, 8'h00);
  endtask

  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) us_tick = 1'b1;
      @(negedge clk) us_tick = 1'b0;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(64'd200000 * 64'd20);
    n_fail++;
    $display("FAIL R11 watchdog: actual busy=%0d expected finished", busy);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) regs[i] = 8'(i);
    regs[8'h10] = 8'hA5;
    regs[8'h22] = 8'h3C;
    clear_tbl();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(!busy && !done && !err_timeout && !err_cmd && !bus_req && !tbl_rd, "R11",
        "reset outputs", {26'd0, busy, done, err_timeout, err_cmd, bus_req, tbl_rd}, 32'd0);

    // ---- Test A: write, two skipped entries, read, skipped bad op, end (R1 R3 R4 R9)
    clear_tbl();
    tbl[0] = mk(4'd1, 4'd2, 16'h0010, 8'h08, 4'h2, 8'h0F, 8'h06);
    tbl[1] = mk(4'd0, 4'd0, 16'h0022, 8'hF7, 4'hF, 8'hFF, 8'h00); // rev bit 3 clear
    tbl[2] = mk(4'd0, 4'd0, 16'h0022, 8'hFF, 4'h5, 8'hFF, 8'h00); // intf bit 1 clear
    tbl[3] = mk(4'd0, 4'd1, 16'h0122, 8'hFF, 4'hF, 8'hF0, 8'h00);
    tbl[4] = mk(4'd9, 4'd0, 16'h0022, 8'h01, 4'hF, 8'hFF, 8'h00); // not applicable
    tbl[5] = mk(4'd4, 4'd0, 16'h0000, 8'hFF, 4'hF, 8'h00, 8'h00);
    tbl[6] = mk(4'd0, 4'd0, 16'h0010, 8'hFF, 4'hF, 8'hFF, 8'h00); // after end
    push_x(1'b0, 20'h20010, 8'hA5);
    push_x(1'b1, 20'h20010, 8'hA6);                 // R4 merge
    push_x(1'b0, 20'h10122, 8'h3C);
    rd_q.push_back(8'h30);                           // R3 masked read
    kick();
    chk(busy && !done, "R11", "busy after start", {30'd0, busy, done}, 32'd2);
    wait_done(2000);
    repeat (6) @(negedge clk);
    chk(done && !busy, "R9", "stopped at end", {30'd0, done, busy}, 32'd2);
    chk(exp_q.size() == 0 && rd_q.size() == 0, "R1", "pending expectations",
        32'(exp_q.size() + rd_q.size()), 32'd0);
    chk(!err_cmd && !err_timeout, "R10", "skipped bad op leaves no error",
        {30'd0, err_cmd, err_timeout}, 32'd0);
    chk(regs[8'h10] == 8'hA6, "R4", "register after write", 32'(regs[8'h10]), 32'hA6);

    // ---- Test B: microsecond delay (R7)
    clear_tbl();
    tbl[0] = mk(4'd3, 4'd0, 16'd5, 8'hFF, 4'hF, 8'h00, 8'h00);
    tbl[1] = mk(4'd0, 4'd0, 16'h0022, 8'hFF, 4'hF, 8'hFF, 8'h00);
    push_x(1'b0, 20'h00022, 8'h3C);
    rd_q.push_back(8'h3C);
    kick();
    repeat (4) @(negedge clk);
    tick_n(4);
    repeat (4) @(negedge clk);
    chk(busy && exp_q.size() == 1, "R7", "still waiting after 4 ticks",
        32'(exp_q.size()), 32'd1);
    tick_n(1);
    wait_done(200);
    repeat (2) @(negedge clk);
    chk(done && exp_q.size() == 0, "R7", "read after 5th tick", 32'(exp_q.size()), 32'd0);

    // ---- Test C: millisecond delay, count 2 (R8)
    clear_tbl();
    tbl[0] = mk(4'd3, 4'd0, 16'd2, 8'hFF, 4'hF, 8'h00, 8'h01);
    tbl[1] = mk(4'd0, 4'd0, 16'h0022, 8'hFF, 4'hF, 8'hFF, 8'h00);
    push_x(1'b0, 20'h00022, 8'h3C);
    rd_q.push_back(8'h3C);
    kick();
    repeat (4) @(negedge clk);
    tick_n(2 * MS_UNITS - 1);
    repeat (4) @(negedge clk);
    chk(busy && exp_q.size() == 1, "R8", "still waiting one tick short",
        32'(exp_q.size()), 32'd1);
    tick_n(1);
    wait_done(200);
    repeat (2) @(negedge clk);
    chk(done && exp_q.size() == 0, "R8", "ms delay finished", 32'(exp_q.size()), 32'd0);

    // ---- Test D: zero-length delay needs no tick (R8)
    clear_tbl();
    tbl[0] = mk(4'd3, 4'd0, 16'd0, 8'hFF, 4'hF, 8'h00, 8'h01);
    tbl[1] = mk(4'd0, 4'd0, 16'h0022, 8'hFF, 4'hF, 8'h0F, 8'h00);
    push_x(1'b0, 20'h00022, 8'h3C);
    rd_q.push_back(8'h0C);
    kick();
    wait_done(200);
    repeat (2) @(negedge clk);
    chk(done && exp_q.size() == 0 && rd_q.size() == 0, "R8", "zero delay immediate",
        {31'd0, done}, 32'd1);

    // ---- Test E: poll succeeds after three misses (R5)
    clear_tbl();
    poll_base = poll_total;
    poll_miss_n = 3;
    tbl[0] = mk(4'd2, 4'd0, 16'h0040, 8'hFF, 4'hF, 8'h81, 8'h81);
    tbl[1] = mk(4'd0, 4'd0, 16'h0022, 8'hFF, 4'hF, 8'hFF, 8'h00);
    for (int i = 0; i < 3; i++) push_x(1'b0, 20'h00040, POLL_MISS);
    push_x(1'b0, 20'h00040, POLL_HIT);
    push_x(1'b0, 20'h00022, 8'h3C);
    rd_q.push_back(8'h3C);
    kick();
    wait_done(500);
    repeat (2) @(negedge clk);
    chk(done && !err_timeout && exp_q.size() == 0, "R5", "poll success path",
        {30'd0, err_timeout, done}, 32'd1);

    // ---- Test F: match on the final allowed read (R6)
    clear_tbl();
    poll_base = poll_total;
    poll_miss_n = LIMIT - 1;
    count_mode = 1'b1;
    begin
      int seen0;
      seen0 = poll_seen;
      tbl[0] = mk(4'd2, 4'd0, 16'h0040, 8'hFF, 4'hF, 8'h81, 8'h81);
      tbl[1] = mk(4'd0, 4'd0, 16'h0022, 8'hFF, 4'hF, 8'hFF, 8'h00);
      push_x(1'b0, 20'h00022, 8'h3C);
      rd_q.push_back(8'h3C);
      kick();
      wait_done(4 * LIMIT);
      repeat (2) @(negedge clk);
      chk(poll_seen - seen0 == LIMIT, "R6", "poll reads, late match", 32'(poll_seen - seen0), 32'(LIMIT));
      chk(!err_timeout && exp_q.size() == 0, "R6", "late match is success",
          {31'd0, err_timeout}, 32'd0);
    end

    // ---- Test G: no match within the limit (R6)
    clear_tbl();
    poll_base = poll_total;
    poll_miss_n = LIMIT;
    begin
      int seen0;
      seen0 = poll_seen;
      tbl[0] = mk(4'd2, 4'd0, 16'h0040, 8'hFF, 4'hF, 8'h81, 8'h81);
      tbl[1] = mk(4'd0, 4'd0, 16'h0022, 8'hFF, 4'hF, 8'hFF, 8'h00);
      kick();
      wait_done(4 * LIMIT);
      repeat (2) @(negedge clk);
      chk(poll_seen - seen0 == LIMIT, "R6", "poll reads, timeout", 32'(poll_seen - seen0), 32'(LIMIT));
      chk(err_timeout && done && !busy, "R6", "timeout flags",
          {29'd0, err_timeout, done, busy}, 32'd6);
      repeat (5) @(negedge clk);
      chk(err_timeout, "R6", "timeout is sticky", {31'd0, err_timeout}, 32'd1);
    end
    count_mode = 1'b0;

    // ---- Test H: applicable bad op (R10), start clears old error (R11)
    clear_tbl();
    tbl[0] = mk(4'hC, 4'd0, 16'h0022, 8'hFF, 4'hF, 8'hFF, 8'h00);
    tbl[1] = mk(4'd0, 4'd0, 16'h0022, 8'hFF, 4'hF, 8'hFF, 8'h00);
    kick();
    chk(!err_timeout && !done, "R11", "start clears error and done",
        {30'd0, err_timeout, done}, 32'd0);
    wait_done(200);
    repeat (4) @(negedge clk);
    chk(err_cmd && done && !busy, "R10", "bad op stops", {29'd0, err_cmd, done, busy}, 32'd6);
    chk(exp_q.size() == 0 && rd_q.size() == 0, "R10", "no transfer after bad op",
        32'(rd_q.size()), 32'd0);

    summary();
    $finish;
  end

endmodule